// File: doc/BRIEF.md
# Adaptive Clock Period Selector

This block turns live variation readings (supply voltage, die temperature, process spread and transistor aging) into a safe clock period. For each functional unit it keeps a table with one entry per point of a four-dimensional grid of quantized conditions. Each entry holds a 2-bit predicted error class for each of the candidate clock periods. On a lookup, the block quantizes the readings onto that grid, toward the pessimistic side. It reads the unit's class vector and returns the shortest candidate period whose predicted class is no worse than the requested target class.

The block runs in one of two adaptation modes. In fine mode, each issued instruction raises a request that names the functional unit it uses. The period is then chosen from that unit's own sensors and that unit's table alone. In coarse mode, one representative set of sensors stands for the whole execution stage. On each kernel-boundary strobe, the block looks up every unit's table and keeps the slowest of the required periods. That result holds until the next strobe. The tables are filled by an offline model through a plain write port. That port is locked out during a lookup cycle.

Top module: `clkp_period_sel`

## Requirements
- R1: The voltage reading (in mV) maps to index floor((mV-880)/10). Readings below 880 mV give index 0. The index saturates at 22, which is 1.10 V.
- R2: Temperature (in °C) maps to ceil(T/10), saturating at 12. Process spread (in units of 0.1 %) maps to ceil(P/32), saturating at 3. Aging shift (in mV) maps to ceil(A/25), saturating at 4.
- R3: A write sets the 50-bit class vector for one grid point of one unit. The point is given by voltage, temperature, process and aging indices. The class for period index k sits in bits [2k+1:2k]. Each unit has its own table, so a write to one unit leaves every other unit's lookups unchanged.
- R4: The result is the smallest period index k (period = 0.2 ns·(k+1), k = 0..24) whose stored class is numerically ≤ the target class. The class codes are 0 = error-free, 1 = low (>0 % to 33 %), 2 = medium (>33 % to 66 %) and 3 = high (>66 %). Target 0 therefore demands error-free operation.
- R5: If no period qualifies, the result is index 24 (5.0 ns) and no_safe_o is 1. Otherwise no_safe_o is 0.
- R6: A fine-mode request (req_valid_i=1, mode_i=0) uses the sensor slice and table of unit req_fu_i. Its result appears with res_valid_o=1 exactly one cycle later.
- R7: A coarse-mode kernel strobe (kernel_start_i=1, mode_i=1) applies the stage sensors to every unit's table. One cycle later it returns the largest required index over all units. no_safe_o is set if any unit has no safe period.
- R8: In coarse mode, req_valid_i is ignored. Whenever no lookup is started, res_valid_o stays 0 the next cycle, and period_idx_o and no_safe_o keep their values.
- R9: A write in a lookup cycle is dropped and wr_err_o pulses high in the following cycle. A write in any other cycle gives wr_err_o=0.
- R10: After reset, period_idx_o=24 and res_valid_o, no_safe_o and wr_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = per-instruction (fine), 1 = per-kernel (coarse) |
| kernel_start_i | input | 1 | Kernel-boundary strobe, starts a coarse lookup |
| req_valid_i | input | 1 | Instruction issue strobe, starts a fine lookup |
| req_fu_i | input | FU_W (1) | Functional unit of the issuing instruction |
| target_cls_i | input | 2 | Worst error class allowed |
| unit_volt_i | input | NUM_FU·11 | Per-unit voltage readings, mV |
| unit_temp_i | input | NUM_FU·8 | Per-unit temperature readings, °C |
| unit_proc_i | input | NUM_FU·7 | Per-unit process spread, 0.1 % units |
| unit_age_i | input | NUM_FU·7 | Per-unit aging shift, mV |
| stage_volt_i | input | 11 | Stage voltage reading, mV |
| stage_temp_i | input | 8 | Stage temperature reading, °C |
| stage_proc_i | input | 7 | Stage process spread, 0.1 % units |
| stage_age_i | input | 7 | Stage aging shift, mV |
| wr_en_i | input | 1 | Table write strobe |
| wr_fu_i | input | FU_W (1) | Unit whose table is written |
| wr_vi_i | input | 5 | Voltage index of the written point |
| wr_ti_i | input | 4 | Temperature index of the written point |
| wr_pi_i | input | 2 | Process index of the written point |
| wr_ai_i | input | 3 | Aging index of the written point |
| wr_cls_i | input | 50 | Class vector, 2 bits per period index |
| res_valid_o | output | 1 | Result update strobe |
| period_idx_o | output | 5 | Selected period index |
| no_safe_o | output | 1 | No candidate met the target |
| wr_err_o | output | 1 | A write was dropped because it collided with a lookup |

## Verification
The checker watches on every cycle the timing relations: a result one cycle after each lookup and never without one, outputs held between lookups, a collision pulse exactly when a write meets a lookup, and the slowest index whenever no period is safe. Whether the chosen index is the right one can only be shown by the bench. To do this it loads every grid point of both tables with a computed pattern and then sweeps readings on and around the grid edges for all four targets in both modes. Dropped writes are proven the same way, by a lookup of the entry that was hit.

// File: rtl/clkp_pkg.sv
package clkp_pkg;
   localparam int CLS_W = 2;
   typedef enum logic {MODE_FINE = 1'b0, MODE_COARSE = 1'b1} adapt_mode_e;
endpackage

// File: rtl/clkp_quant.sv
module clkp_quant #(
   parameter int RAW_W    = 8,
   parameter int MIN      = 0,
   parameter int STEP     = 10,
   parameter int PTS      = 13,
   parameter int IDX_W    = 4,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic [RAW_W-1:0] raw,
   output logic [IDX_W-1:0] idx
);
   localparam int OW = RAW_W + 1;
   logic [OW-1:0] off;
   logic [OW-1:0] q;

   always_comb off = ({1'b0, raw} < OW'(MIN)) ? '0 : ({1'b0, raw} - OW'(MIN));

   generate
      if (ROUND_UP) begin : g_ceil
         always_comb q = (off + OW'(STEP - 1)) / OW'(STEP);
      end else begin : g_floor
         always_comb q = off / OW'(STEP);
      end
   endgenerate

   always_comb idx = (q > OW'(PTS - 1)) ? IDX_W'(PTS - 1) : q[IDX_W-1:0];
endmodule

// File: rtl/clkp_unit_table.sv
module clkp_unit_table #(
   parameter int ROWS   = 299,
   parameter int CHUNKS = 20,
   parameter int ROW_W  = 9,
   parameter int CH_W   = 5,
   parameter int VEC_W  = 50
) (
   input  logic             clk,
   input  logic             we,
   input  logic [ROW_W-1:0] wrow,
   input  logic [CH_W-1:0]  wchunk,
   input  logic [VEC_W-1:0] wdata,
   input  logic [ROW_W-1:0] rrow,
   input  logic [CH_W-1:0]  rchunk,
   output logic [VEC_W-1:0] rdata
);
   logic [CHUNKS*VEC_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we && ({1'b0, wrow} < (ROW_W+1)'(ROWS)))
         mem[wrow][wchunk*VEC_W +: VEC_W] <= wdata;
   end

   assign rdata = mem[rrow][rchunk*VEC_W +: VEC_W];
endmodule

// File: rtl/clkp_pick.sv
module clkp_pick #(
   parameter int NPER  = 25,
   parameter int CLS_W = 2,
   parameter int PI_W  = 5
) (
   input  logic [NPER*CLS_W-1:0] cls_vec,
   input  logic [CLS_W-1:0]      target,
   output logic [PI_W-1:0]       idx,
   output logic                  none
);
   always_comb begin
      idx  = PI_W'(NPER - 1);
      none = 1'b1;
      for (int k = NPER - 1; k >= 0; k--) begin
         if (cls_vec[k*CLS_W +: CLS_W] <= target) begin
            idx  = PI_W'(k);
            none = 1'b0;
         end
      end
   end
endmodule

// File: rtl/clkp_period_sel.sv
module clkp_period_sel
   import clkp_pkg::*;
#(
   parameter int NUM_FU = 2,
   parameter int VRAW_W = 11,
   parameter int TRAW_W = 8,
   parameter int PRAW_W = 7,
   parameter int ARAW_W = 7,
   parameter int V_MIN  = 880,
   parameter int V_STEP = 10,
   parameter int V_PTS  = 23,
   parameter int T_STEP = 10,
   parameter int T_PTS  = 13,
   parameter int P_STEP = 32,
   parameter int P_PTS  = 4,
   parameter int A_STEP = 25,
   parameter int A_PTS  = 5,
   parameter int NPER   = 25,
   localparam int FU_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
   localparam int VI_W  = $clog2(V_PTS),
   localparam int TI_W  = $clog2(T_PTS),
   localparam int PX_W  = $clog2(P_PTS),
   localparam int AI_W  = $clog2(A_PTS),
   localparam int PI_W  = $clog2(NPER),
   localparam int VEC_W = CLS_W * NPER
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_i,
   input  logic                     kernel_start_i,
   input  logic                     req_valid_i,
   input  logic [FU_W-1:0]          req_fu_i,
   input  logic [CLS_W-1:0]         target_cls_i,
   input  logic [NUM_FU*VRAW_W-1:0] unit_volt_i,
   input  logic [NUM_FU*TRAW_W-1:0] unit_temp_i,
   input  logic [NUM_FU*PRAW_W-1:0] unit_proc_i,
   input  logic [NUM_FU*ARAW_W-1:0] unit_age_i,
   input  logic [VRAW_W-1:0]        stage_volt_i,
   input  logic [TRAW_W-1:0]        stage_temp_i,
   input  logic [PRAW_W-1:0]        stage_proc_i,
   input  logic [ARAW_W-1:0]        stage_age_i,
   input  logic                     wr_en_i,
   input  logic [FU_W-1:0]          wr_fu_i,
   input  logic [VI_W-1:0]          wr_vi_i,
   input  logic [TI_W-1:0]          wr_ti_i,
   input  logic [PX_W-1:0]          wr_pi_i,
   input  logic [AI_W-1:0]          wr_ai_i,
   input  logic [VEC_W-1:0]         wr_cls_i,
   output logic                     res_valid_o,
   output logic [PI_W-1:0]          period_idx_o,
   output logic                     no_safe_o,
   output logic                     wr_err_o
);
   localparam int ROWS   = V_PTS * T_PTS;
   localparam int CHUNKS = P_PTS * A_PTS;
   localparam int ROW_W  = $clog2(ROWS);
   localparam int CH_W   = $clog2(CHUNKS);

   if (NUM_FU < 1) begin : g_bad_fu
      $error("NUM_FU must be at least 1");
   end
   if (NPER < 2 || V_PTS < 2 || T_PTS < 2 || P_PTS < 2 || A_PTS < 2) begin : g_bad_grid
      $error("every grid axis and the period list need two or more points");
   end
   if (V_MIN + V_STEP * (V_PTS - 1) >= 2 ** VRAW_W) begin : g_bad_vraw
      $error("voltage grid does not fit the raw reading width");
   end

   logic coarse;
   logic go;
   assign coarse = (adapt_mode_e'(mode_i) == MODE_COARSE);
   assign go     = coarse ? kernel_start_i : req_valid_i;

   // Stage sensor quantization, shared by all units in coarse mode
   logic [VI_W-1:0] st_vi;
   logic [TI_W-1:0] st_ti;
   logic [PX_W-1:0] st_pi;
   logic [AI_W-1:0] st_ai;

   clkp_quant #(.RAW_W(VRAW_W), .MIN(V_MIN), .STEP(V_STEP), .PTS(V_PTS), .IDX_W(VI_W), .ROUND_UP(1'b0))
      u_st_v (.raw(stage_volt_i), .idx(st_vi));
   clkp_quant #(.RAW_W(TRAW_W), .MIN(0), .STEP(T_STEP), .PTS(T_PTS), .IDX_W(TI_W), .ROUND_UP(1'b1))
      u_st_t (.raw(stage_temp_i), .idx(st_ti));
   clkp_quant #(.RAW_W(PRAW_W), .MIN(0), .STEP(P_STEP), .PTS(P_PTS), .IDX_W(PX_W), .ROUND_UP(1'b1))
      u_st_p (.raw(stage_proc_i), .idx(st_pi));
   clkp_quant #(.RAW_W(ARAW_W), .MIN(0), .STEP(A_STEP), .PTS(A_PTS), .IDX_W(AI_W), .ROUND_UP(1'b1))
      u_st_a (.raw(stage_age_i), .idx(st_ai));

   logic [ROW_W-1:0] wrow;
   logic [CH_W-1:0]  wchunk;
   assign wrow   = ROW_W'(wr_vi_i) * ROW_W'(T_PTS) + ROW_W'(wr_ti_i);
   assign wchunk = CH_W'(wr_pi_i) * CH_W'(A_PTS) + CH_W'(wr_ai_i);

   logic [PI_W-1:0] pick_idx  [NUM_FU];
   logic            pick_none [NUM_FU];

   for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
      logic [VI_W-1:0]  u_vi, s_vi;
      logic [TI_W-1:0]  u_ti, s_ti;
      logic [PX_W-1:0]  u_pi, s_pi;
      logic [AI_W-1:0]  u_ai, s_ai;
      logic [ROW_W-1:0] rrow;
      logic [CH_W-1:0]  rchunk;
      logic [VEC_W-1:0] cls_vec;

      clkp_quant #(.RAW_W(VRAW_W), .MIN(V_MIN), .STEP(V_STEP), .PTS(V_PTS), .IDX_W(VI_W), .ROUND_UP(1'b0))
         u_q_v (.raw(unit_volt_i[f*VRAW_W +: VRAW_W]), .idx(u_vi));
      clkp_quant #(.RAW_W(TRAW_W), .MIN(0), .STEP(T_STEP), .PTS(T_PTS), .IDX_W(TI_W), .ROUND_UP(1'b1))
         u_q_t (.raw(unit_temp_i[f*TRAW_W +: TRAW_W]), .idx(u_ti));
      clkp_quant #(.RAW_W(PRAW_W), .MIN(0), .STEP(P_STEP), .PTS(P_PTS), .IDX_W(PX_W), .ROUND_UP(1'b1))
         u_q_p (.raw(unit_proc_i[f*PRAW_W +: PRAW_W]), .idx(u_pi));
      clkp_quant #(.RAW_W(ARAW_W), .MIN(0), .STEP(A_STEP), .PTS(A_PTS), .IDX_W(AI_W), .ROUND_UP(1'b1))
         u_q_a (.raw(unit_age_i[f*ARAW_W +: ARAW_W]), .idx(u_ai));

      assign s_vi   = coarse ? st_vi : u_vi;
      assign s_ti   = coarse ? st_ti : u_ti;
      assign s_pi   = coarse ? st_pi : u_pi;
      assign s_ai   = coarse ? st_ai : u_ai;
      assign rrow   = ROW_W'(s_vi) * ROW_W'(T_PTS) + ROW_W'(s_ti);
      assign rchunk = CH_W'(s_pi) * CH_W'(A_PTS) + CH_W'(s_ai);

      clkp_unit_table #(.ROWS(ROWS), .CHUNKS(CHUNKS), .ROW_W(ROW_W), .CH_W(CH_W), .VEC_W(VEC_W))
         u_tab (
            .clk    (clk),
            .we     (wr_en_i && !go && (wr_fu_i == FU_W'(f))),
            .wrow   (wrow),
            .wchunk (wchunk),
            .wdata  (wr_cls_i),
            .rrow   (rrow),
            .rchunk (rchunk),
            .rdata  (cls_vec)
         );

      clkp_pick #(.NPER(NPER), .CLS_W(CLS_W), .PI_W(PI_W))
         u_pick (.cls_vec(cls_vec), .target(target_cls_i), .idx(pick_idx[f]), .none(pick_none[f]));
   end

   logic [PI_W-1:0] fine_idx, crs_idx;
   logic            fine_none, crs_none;

   always_comb begin
      fine_idx  = PI_W'(NPER - 1);
      fine_none = 1'b1;
      crs_idx   = '0;
      crs_none  = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
         if (FU_W'(f) == req_fu_i) begin
            fine_idx  = pick_idx[f];
            fine_none = pick_none[f];
         end
         if (pick_idx[f] > crs_idx) crs_idx = pick_idx[f];
         crs_none = crs_none | pick_none[f];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_o  <= 1'b0;
         period_idx_o <= PI_W'(NPER - 1);
         no_safe_o    <= 1'b0;
         wr_err_o     <= 1'b0;
      end else begin
         res_valid_o <= go;
         wr_err_o    <= wr_en_i && go;
         if (go) begin
            period_idx_o <= coarse ? crs_idx  : fine_idx;
            no_safe_o    <= coarse ? crs_none : fine_none;
         end
      end
   end
endmodule

// File: rtl/clkp_period_sel_chk.sv
module clkp_period_sel_chk #(
   parameter int PI_W = 5,
   parameter int NPER = 25
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode_i,
   input logic            kernel_start_i,
   input logic            req_valid_i,
   input logic            wr_en_i,
   input logic            res_valid_o,
   input logic [PI_W-1:0] period_idx_o,
   input logic            no_safe_o,
   input logic            wr_err_o
);
   logic start;
   assign start = mode_i ? kernel_start_i : req_valid_i;

   AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> res_valid_o);                                                        // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (!res_valid_o && $stable(period_idx_o) && $stable(no_safe_o)));      // R8
   AST_WR_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && start) |=> wr_err_o);                                               // R9
   AST_WR_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && start) |=> !wr_err_o);                                             // R9
   AST_NOSAFE_SLOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      no_safe_o |-> (period_idx_o == PI_W'(NPER - 1)));                               // R5
   AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      period_idx_o <= PI_W'(NPER - 1));                                               // R4
endmodule

bind clkp_period_sel clkp_period_sel_chk #(.PI_W(PI_W), .NPER(NPER)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_i         (mode_i),
   .kernel_start_i (kernel_start_i),
   .req_valid_i    (req_valid_i),
   .wr_en_i        (wr_en_i),
   .res_valid_o    (res_valid_o),
   .period_idx_o   (period_idx_o),
   .no_safe_o      (no_safe_o),
   .wr_err_o       (wr_err_o)
);

// File: tb/clkp_period_sel_tb_top.sv
module clkp_period_sel_tb_top;
   localparam int NFU = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode = 1'b0;
   logic        kstart = 1'b0;
   logic        req_valid = 1'b0;
   logic [0:0]  req_fu = '0;
   logic [1:0]  target = '0;
   logic [21:0] unit_volt = '0;
   logic [15:0] unit_temp = '0;
   logic [13:0] unit_proc = '0;
   logic [13:0] unit_age = '0;
   logic [10:0] stage_volt = '0;
   logic [7:0]  stage_temp = '0;
   logic [6:0]  stage_proc = '0;
   logic [6:0]  stage_age = '0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_fu = '0;
   logic [4:0]  wr_vi = '0;
   logic [3:0]  wr_ti = '0;
   logic [1:0]  wr_pi = '0;
   logic [2:0]  wr_ai = '0;
   logic [49:0] wr_cls = '0;
   logic        res_valid;
   logic [4:0]  period_idx;
   logic        no_safe;
   logic        wr_err;

   int checks = 0;
   int fails = 0;

   always #2 clk = ~clk;

   clkp_period_sel dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .kernel_start_i(kstart),
      .req_valid_i(req_valid), .req_fu_i(req_fu), .target_cls_i(target),
      .unit_volt_i(unit_volt), .unit_temp_i(unit_temp), .unit_proc_i(unit_proc), .unit_age_i(unit_age),
      .stage_volt_i(stage_volt), .stage_temp_i(stage_temp), .stage_proc_i(stage_proc), .stage_age_i(stage_age),
      .wr_en_i(wr_en), .wr_fu_i(wr_fu), .wr_vi_i(wr_vi), .wr_ti_i(wr_ti), .wr_pi_i(wr_pi), .wr_ai_i(wr_ai),
      .wr_cls_i(wr_cls), .res_valid_o(res_valid), .period_idx_o(period_idx), .no_safe_o(no_safe),
      .wr_err_o(wr_err)
   );

   function automatic int qv(int mv);
      int q;
      if (mv < 880) return 0;
      q = (mv - 880) / 10;
      return (q > 22) ? 22 : q;
   endfunction

   function automatic int qc(int raw, int step, int top);
      int q = (raw + step - 1) / step;
      return (q > top) ? top : q;
   endfunction

   function automatic int basef(int fu, int vi, int ti, int pi, int ai);
      return fu * 3 + (22 - vi) / 2 + ti / 2 + pi + ai;
   endfunction

   function automatic int needf(int b, int tg);
      int n;
      if (tg == 3) return 0;
      n = b - 3 * tg;
      return (n < 0) ? 0 : n;
   endfunction

   function automatic logic [49:0] vecf(int b);
      logic [49:0] v;
      for (int k = 0; k < 25; k++) begin
         int c;
         c = (k >= b) ? 0 : ((k + 3 >= b) ? 1 : ((k + 6 >= b) ? 2 : 3));
         v[2*k +: 2] = 2'(c);
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_unit(input int fu, input int v, input int t, input int p, input int a);
      for (int f = 0; f < NFU; f++) begin
         if (f == fu) begin
            unit_volt[f*11 +: 11] = 11'(v);
            unit_temp[f*8 +: 8]   = 8'(t);
            unit_proc[f*7 +: 7]   = 7'(p);
            unit_age[f*7 +: 7]    = 7'(a);
         end else begin
            unit_volt[f*11 +: 11] = 11'(800);
            unit_temp[f*8 +: 8]   = 8'(200);
            unit_proc[f*7 +: 7]   = 7'(127);
            unit_age[f*7 +: 7]    = 7'(127);
         end
      end
   endtask

   task automatic fine_look(input int fu, input int v, input int t, input int p, input int a, input int tg);
      int n, e;
      @(negedge clk);
      set_unit(fu, v, t, p, a);
      mode = 1'b0; req_fu = 1'(fu); target = 2'(tg); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = needf(basef(fu, qv(v), qc(t, 10, 12), qc(p, 32, 3), qc(a, 25, 4)), tg);
      e = (n > 24) ? 24 : n;
      chk(res_valid == 1'b1, "R6 fine result strobe", int'(res_valid), 1);
      chk(int'(period_idx) == e, "R1 R2 R4 fine index", int'(period_idx), e);
      chk(int'(no_safe) == int'(n > 24), "R5 fine no-safe flag", int'(no_safe), int'(n > 24));
   endtask

   task automatic coarse_look(input int v, input int t, input int p, input int a, input int tg);
      int mx, n;
      bit nz;
      logic [4:0] held_idx;
      logic       held_ns;
      @(negedge clk);
      stage_volt = 11'(v); stage_temp = 8'(t); stage_proc = 7'(p); stage_age = 7'(a);
      set_unit(0, 1100, 0, 0, 0);
      mode = 1'b1; target = 2'(tg); kstart = 1'b1;
      @(negedge clk);
      kstart = 1'b0;
      mx = 0; nz = 1'b0;
      for (int f = 0; f < NFU; f++) begin
         n = needf(basef(f, qv(v), qc(t, 10, 12), qc(p, 32, 3), qc(a, 25, 4)), tg);
         if (n > 24) begin nz = 1'b1; n = 24; end
         if (n > mx) mx = n;
      end
      chk(res_valid == 1'b1, "R7 coarse result strobe", int'(res_valid), 1);
      chk(int'(period_idx) == mx, "R7 coarse max index", int'(period_idx), mx);
      chk(no_safe == nz, "R7 coarse no-safe flag", int'(no_safe), int'(nz));
      held_idx = period_idx; held_ns = no_safe;
      // R8: instruction strobe in coarse mode with changed readings
      stage_volt = 11'(800); stage_temp = 8'(200); stage_proc = 7'(127); stage_age = 7'(127);
      target = 2'(0); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(res_valid == 1'b0, "R8 no strobe on ignored request", int'(res_valid), 0);
      chk(period_idx == held_idx && no_safe == held_ns, "R8 coarse result held",
          int'(period_idx), int'(held_idx));
   endtask

   int vl[6] = '{800, 880, 885, 1000, 1100, 1150};
   int tl[6] = '{0, 1, 10, 55, 120, 200};
   int pl[6] = '{0, 1, 32, 33, 96, 127};
   int al[6] = '{0, 24, 25, 26, 100, 127};

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk(int'(period_idx) == 24, "R10 reset index", int'(period_idx), 24);
      chk(res_valid == 1'b0 && no_safe == 1'b0 && wr_err == 1'b0, "R10 reset flags",
          int'({res_valid, no_safe, wr_err}), 0);

      // R3 load every grid point of both tables
      for (int f = 0; f < NFU; f++)
         for (int v = 0; v < 23; v++)
            for (int t = 0; t < 13; t++)
               for (int p = 0; p < 4; p++)
                  for (int a = 0; a < 5; a++) begin
                     @(negedge clk);
                     wr_en = 1'b1; wr_fu = 1'(f); wr_vi = 5'(v); wr_ti = 4'(t);
                     wr_pi = 2'(p); wr_ai = 3'(a); wr_cls = vecf(basef(f, v, t, p, a));
                  end
      @(negedge clk);
      wr_en = 1'b0;
      chk(wr_err == 1'b0, "R9 clean write raises no error", int'(wr_err), 0);

      // R6 R1 R2 R4 R5 fine sweep
      for (int f = 0; f < NFU; f++)
         for (int iv = 0; iv < 6; iv++)
            for (int it = 0; it < 6; it++)
               for (int ip = 0; ip < 6; ip++)
                  for (int ia = 0; ia < 6; ia++)
                     for (int tg = 0; tg < 4; tg++)
                        fine_look(f, vl[iv], tl[it], pl[ip], al[ia], tg);

      // R7 R8 coarse sweep
      for (int iv = 0; iv < 6; iv++)
         for (int it = 0; it < 6; it++)
            for (int ip = 0; ip < 6; ip++)
               for (int ia = 0; ia < 6; ia++)
                  coarse_look(vl[iv], tl[it], pl[ip], al[ia], ia % 4);

      // R9 write colliding with a fine lookup is dropped
      @(negedge clk);
      set_unit(0, 880, 0, 0, 0);
      mode = 1'b0; req_fu = 1'b0; target = 2'(0); req_valid = 1'b1;
      wr_en = 1'b1; wr_fu = 1'b0; wr_vi = '0; wr_ti = '0; wr_pi = '0; wr_ai = '0; wr_cls = '0;
      @(negedge clk);
      req_valid = 1'b0; wr_en = 1'b0;
      chk(wr_err == 1'b1, "R9 collision error pulse", int'(wr_err), 1);
      chk(int'(period_idx) == 11, "R9 colliding lookup index", int'(period_idx), 11);
      @(negedge clk);
      chk(wr_err == 1'b0, "R9 error pulse lasts one cycle", int'(wr_err), 0);
      fine_look(0, 880, 0, 0, 0, 0);

      // R3 accepted write takes effect and stays in its own unit
      @(negedge clk);
      wr_en = 1'b1; wr_fu = 1'b0; wr_cls = '0;
      @(negedge clk);
      wr_en = 1'b0;
      chk(wr_err == 1'b0, "R9 idle write raises no error", int'(wr_err), 0);
      set_unit(0, 880, 0, 0, 0);
      mode = 1'b0; req_fu = 1'b0; target = 2'(0); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(int'(period_idx) == 0, "R3 written vector used", int'(period_idx), 0);
      fine_look(1, 880, 0, 0, 0, 0);
      @(negedge clk);
      wr_en = 1'b1; wr_fu = 1'b0; wr_cls = vecf(11);
      @(negedge clk);
      wr_en = 1'b0;

      // R9 write colliding with a kernel strobe is dropped
      stage_volt = 11'(880); stage_temp = '0; stage_proc = '0; stage_age = '0;
      mode = 1'b1; kstart = 1'b1; target = 2'(0);
      wr_en = 1'b1; wr_fu = 1'b0; wr_cls = '0;
      @(negedge clk);
      kstart = 1'b0; wr_en = 1'b0;
      chk(wr_err == 1'b1, "R9 coarse collision error pulse", int'(wr_err), 1);
      chk(int'(period_idx) == 14, "R7 coarse index during collision", int'(period_idx), 14);
      fine_look(0, 880, 0, 0, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule